// File: doc/BRIEF.md
# 2100 Hz Answer-Tone Detector

The block watches a stream of 16-bit signed linear PCM samples arriving at an 8 kHz rate and decides whether a 2100 Hz tone is present. Samples are gathered into fixed blocks of 536 samples, which is 67 ms at 8 kHz. Over each block a single-frequency Goertzel recursion measures the energy near 2100 Hz while a second accumulator sums the total signal energy. When a block ends, the block is judged positive if the tone energy accounts for more than half of the block's energy and the block's energy also clears a fixed floor.

Block verdicts feed a debounce stage. The stage sets a sticky flag only after a run of consecutive positive blocks whose length is programmed in 67 ms units. The flag stays set until an explicit clear pulse, even after the tone has gone. A single enable input stops all processing so that the detector can be idled once the tone window has passed. One instance is placed on each signal direction that needs watching.

Two small state machines set the control flow. The accumulator machine has two states. ACC_OFF holds the sums and the sample counter at zero and is entered whenever `det_en` is low. ACC_RUN takes one valid sample per cycle and is entered whenever `det_en` is high. The debounce machine has three states. DB_OFF is entered from any state when `det_en` is low. DB_HUNT means no positive run is in progress: it is entered from DB_OFF on enable, and from DB_TRACK on a negative block. DB_TRACK means a run is in progress: it is entered from DB_HUNT, or directly from DB_OFF, on a positive block, and it stays put on further positive blocks.

Top module: `tone2100_det`

## Requirements
- R1: After reset `tone_seen` is 0, and the sample count, the partial sums and the positive-run count are all zero.
- R2: A verdict is formed only when exactly 536 accepted samples have made up a block. 535 samples give no verdict, and the sums restart at zero for the next block.
- R3: A block is positive only when the 2100 Hz bin holds more than half of the block's energy. A 2100 Hz tone wins against a weaker 1000 Hz tone and loses against a stronger one, and a lone 1000 Hz tone is negative.
- R4: A block whose summed squared samples do not exceed FLOOR (default 8,388,608) is negative, even if it is a pure 2100 Hz tone.
- R5: With `db_blocks` = N > 0, `tone_seen` rises only on the Nth consecutive positive block.
- R6: Any negative block resets the consecutive-positive count to zero.
- R7: `db_blocks` = 0 behaves as 1, so a single positive block is enough.
- R8: Once set, `tone_seen` stays 1 through later negative blocks until it is cleared.
- R9: A cycle with `stat_clr` high clears `tone_seen` on the next edge. When a clear and a set fall on the same edge, the clear wins.
- R10: While `det_en` is low, samples are ignored, and a partial block and the positive-run count are both discarded. `tone_seen` keeps its value.
- R11: Only cycles with `smp_vld` high add to a block. Data presented on other cycles has no effect.
- R12: `tone_seen` rises at the second clock edge after the edge that accepts a block's last sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| det_en | input | 1 | Detector enable; low idles and flushes the detector |
| smp_vld | input | 1 | `smp_data` holds a new sample this cycle |
| smp_data | input | SMP_W | Signed linear PCM sample |
| db_blocks | input | DB_W | Required count of consecutive positive 67 ms blocks (0 is treated as 1) |
| stat_clr | input | 1 | Clear pulse for `tone_seen` |
| tone_seen | output | 1 | Sticky tone-detected flag |

## Verification
A wrong internal state mostly shows up at `tone_seen` one whole block later, because the only observable output is the debounced flag. A sample counter that is off by one moves every later block boundary. This shows as a flag rising one cycle early or late in the R12 timing check, or as a missed detection once the block boundaries drift away from the tone stimulus. A positive-run count that is not cleared on a negative block or on disable shows as an early flag within one block of the N-block debounce sequences. A broken energy comparison shows within a single block on the mixed-tone and quiet-tone patterns.

// File: rtl/tone2100_pkg.sv
`timescale 1ns/1ps
package tone2100_pkg;
    typedef enum logic [0:0] {ACC_OFF, ACC_RUN} acc_st_t;
    typedef enum logic [1:0] {DB_OFF, DB_HUNT, DB_TRACK} db_st_t;
    localparam int COEF_W = 16;
endpackage

// File: rtl/tone_goertzel_acc.sv
`timescale 1ns/1ps
module tone_goertzel_acc
    import tone2100_pkg::*;
#(
    parameter int SMP_W     = 16,
    parameter int STATE_W   = 28,
    parameter int EN_W      = 42,
    parameter int BLOCK_LEN = 536,
    parameter int COEF_Q    = 14,
    parameter int COEF      = -2571
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic                      vld,
    input  logic signed [SMP_W-1:0]   smp,
    output logic                      done,
    output logic signed [STATE_W-1:0] s1_o,
    output logic signed [STATE_W-1:0] s2_o,
    output logic [EN_W-1:0]           e_o
);
    localparam int CNT_W = $clog2(BLOCK_LEN);
    localparam int MW    = STATE_W + COEF_W;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLOCK_LEN - 1);
    localparam logic signed [COEF_W-1:0] K = COEF_W'(COEF);

    acc_st_t st, st_nx;
    logic signed [STATE_W-1:0] s1, s2, s_new;
    logic [EN_W-1:0]           eng, e_add;
    logic [CNT_W-1:0]          cnt;
    logic signed [MW-1:0]      prod, fb, s_wide;
    logic signed [2*SMP_W-1:0] sq;

    // one Goertzel step: s = x + k*s1 - s2, with k in Q14
    always_comb begin
        prod   = $signed({{STATE_W{K[COEF_W-1]}}, K}) *
                 $signed({{COEF_W{s1[STATE_W-1]}}, s1});
        fb     = prod >>> COEF_Q;
        s_wide = $signed({{(MW-SMP_W){smp[SMP_W-1]}}, smp}) + fb -
                 $signed({{COEF_W{s2[STATE_W-1]}}, s2});
        s_new  = s_wide[STATE_W-1:0];
        sq     = $signed({{SMP_W{smp[SMP_W-1]}}, smp}) *
                 $signed({{SMP_W{smp[SMP_W-1]}}, smp});
        e_add  = eng + EN_W'($unsigned(sq));
    end

    always_comb st_nx = en ? ACC_RUN : ACC_OFF;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ACC_OFF;
            s1   <= '0;
            s2   <= '0;
            eng  <= '0;
            cnt  <= '0;
            done <= 1'b0;
            s1_o <= '0;
            s2_o <= '0;
            e_o  <= '0;
        end else begin
            st   <= st_nx;
            done <= 1'b0;
            unique case (st_nx)
                ACC_OFF: begin
                    s1  <= '0;
                    s2  <= '0;
                    eng <= '0;
                    cnt <= '0;
                end
                ACC_RUN: begin
                    if (vld) begin
                        if (cnt == LAST) begin
                            done <= 1'b1;
                            s1_o <= s_new;
                            s2_o <= s1;
                            e_o  <= e_add;
                            s1   <= '0;
                            s2   <= '0;
                            eng  <= '0;
                            cnt  <= '0;
                        end else begin
                            s2  <= s1;
                            s1  <= s_new;
                            eng <= e_add;
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);                                          // R2
    AST_DONE_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(en && vld));                            // R11
    AST_OFF_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0 && eng == '0 && !done));            // R10
endmodule

// File: rtl/tone_block_judge.sv
`timescale 1ns/1ps
module tone_block_judge
    import tone2100_pkg::*;
#(
    parameter int          STATE_W   = 28,
    parameter int          EN_W      = 42,
    parameter int          BLOCK_LEN = 536,
    parameter int          COEF_Q    = 14,
    parameter int          COEF      = -2571,
    parameter longint unsigned FLOOR = 64'd8388608
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      done,
    input  logic signed [STATE_W-1:0] s1,
    input  logic signed [STATE_W-1:0] s2,
    input  logic [EN_W-1:0]           e,
    output logic                      jv,
    output logic                      jpos
);
    localparam int PW = 2*STATE_W + 4;
    localparam int CW = PW + 2;
    localparam logic signed [COEF_W-1:0] K = COEF_W'(COEF);
    localparam logic [EN_W-1:0] FLR = EN_W'(FLOOR);

    logic signed [PW-1:0] s1x, s2x, kx, t, p;
    logic [CW-1:0] bin4, tot_n;
    logic          pos;

    // bin power = s1^2 + s2^2 - k*s1*s2; positive when 4*P > N*E
    always_comb begin
        s1x   = $signed({{(PW-STATE_W){s1[STATE_W-1]}}, s1});
        s2x   = $signed({{(PW-STATE_W){s2[STATE_W-1]}}, s2});
        kx    = $signed({{(PW-COEF_W){K[COEF_W-1]}}, K});
        t     = (kx * s1x) >>> COEF_Q;
        p     = s1x * s1x + s2x * s2x - t * s2x;
        bin4  = {p, 2'b00};
        tot_n = CW'(e) * CW'(BLOCK_LEN);
        pos   = !p[PW-1] && (bin4 > tot_n) && (e > FLR);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            jv   <= 1'b0;
            jpos <= 1'b0;
        end else begin
            jv   <= done;
            jpos <= done && pos;
        end
    end

    AST_QUIET_NEGATIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && e <= FLR) |=> (jv && !jpos));                 // R4
endmodule

// File: rtl/tone_debounce.sv
`timescale 1ns/1ps
module tone_debounce
    import tone2100_pkg::*;
#(
    parameter int DB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            jv,
    input  logic            jpos,
    input  logic [DB_W-1:0] db_n,
    input  logic            clr,
    output logic            status
);
    localparam logic [DB_W-1:0] ONE = DB_W'(1);
    localparam logic [DB_W-1:0] SAT = '1;

    db_st_t          st, st_nx;
    logic [DB_W-1:0] run, need;
    logic [DB_W:0]   run_sum;
    logic            hit;

    always_comb begin
        need    = (db_n == '0) ? ONE : db_n;
        run_sum = {1'b0, run} + (DB_W+1)'(1);
        hit     = en && jv && jpos && (run_sum >= {1'b0, need});
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            DB_OFF:   st_nx = !en ? DB_OFF : ((jv && jpos) ? DB_TRACK : DB_HUNT);
            DB_HUNT:  st_nx = !en ? DB_OFF : ((jv && jpos) ? DB_TRACK : DB_HUNT);
            DB_TRACK: st_nx = !en ? DB_OFF : ((jv && !jpos) ? DB_HUNT : DB_TRACK);
            default:  st_nx = DB_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= DB_OFF;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= '0;
            status <= 1'b0;
        end else begin
            unique case (st_nx)
                DB_OFF, DB_HUNT: run <= '0;
                DB_TRACK: if (jv && jpos) run <= (run == SAT) ? run : run + 1'b1;
                default: run <= '0;
            endcase
            if (clr)      status <= 1'b0;
            else if (hit) status <= 1'b1;
        end
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !clr) |=> status);                          // R8
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !status);                                      // R9
    AST_SET_ON_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> $past(en && jv && jpos));            // R5
    AST_NEG_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && jv && !jpos) |=> (run == '0));                  // R6
    AST_OFF_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (run == '0 && st == DB_OFF));                  // R10
endmodule

// File: rtl/tone2100_det.sv
`timescale 1ns/1ps
module tone2100_det
    import tone2100_pkg::*;
#(
    parameter int          SMP_W     = 16,
    parameter int          BLOCK_LEN = 536,
    parameter int          DB_W      = 8,
    parameter int          COEF_Q    = 14,
    parameter int          COEF      = -2571,
    parameter longint unsigned FLOOR = 64'd8388608
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    det_en,
    input  logic                    smp_vld,
    input  logic signed [SMP_W-1:0] smp_data,
    input  logic [DB_W-1:0]         db_blocks,
    input  logic                    stat_clr,
    output logic                    tone_seen
);
    localparam int CNT_W   = $clog2(BLOCK_LEN);
    localparam int EN_W    = 2*SMP_W + CNT_W;
    localparam int STATE_W = SMP_W + CNT_W + 2;

    logic                      blk_done, jv, jpos;
    logic signed [STATE_W-1:0] s1, s2;
    logic [EN_W-1:0]           e;

    tone_goertzel_acc #(
        .SMP_W(SMP_W), .STATE_W(STATE_W), .EN_W(EN_W),
        .BLOCK_LEN(BLOCK_LEN), .COEF_Q(COEF_Q), .COEF(COEF)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .en(det_en), .vld(smp_vld), .smp(smp_data),
        .done(blk_done), .s1_o(s1), .s2_o(s2), .e_o(e)
    );

    tone_block_judge #(
        .STATE_W(STATE_W), .EN_W(EN_W), .BLOCK_LEN(BLOCK_LEN),
        .COEF_Q(COEF_Q), .COEF(COEF), .FLOOR(FLOOR)
    ) u_judge (
        .clk(clk), .rst_n(rst_n), .done(blk_done), .s1(s1), .s2(s2), .e(e),
        .jv(jv), .jpos(jpos)
    );

    tone_debounce #(.DB_W(DB_W)) u_deb (
        .clk(clk), .rst_n(rst_n), .en(det_en), .jv(jv), .jpos(jpos),
        .db_n(db_blocks), .clr(stat_clr), .status(tone_seen)
    );
endmodule

// File: tb/tone2100_det_tb.sv
`timescale 1ns/1ps
module tone2100_det_tb;
    localparam int  BL = 536;
    localparam real PI = 3.14159265358979;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              det_en = 1'b0;
    logic              smp_vld = 1'b0;
    logic signed [15:0] smp_data = '0;
    logic [7:0]        db_blocks = 8'd1;
    logic              stat_clr = 1'b0;
    logic              tone_seen;

    int  n_cmp = 0;
    int  n_bad = 0;
    int  nidx  = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    tone2100_det u_dut (
        .clk(clk), .rst_n(rst_n), .det_en(det_en), .smp_vld(smp_vld),
        .smp_data(smp_data), .db_blocks(db_blocks), .stat_clr(stat_clr),
        .tone_seen(tone_seen)
    );

    function automatic logic signed [15:0] gen(real a1, real f1, real a2, real f2, int k);
        real v;
        v = a1 * $sin(2.0*PI*f1*k/8000.0) + a2 * $sin(2.0*PI*f2*k/8000.0);
        return 16'($rtoi(v));
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: tone_seen=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // call at a negedge; the sample is taken at the following posedge
    task automatic put(logic signed [15:0] x);
        smp_data = x;
        smp_vld  = 1'b1;
        @(negedge clk);
        smp_vld  = 1'b0;
    endtask

    task automatic feed(int cnt, real a1, real f1, real a2, real f2, int gap);
        for (int i = 0; i < cnt; i++) begin
            put(gen(a1, f1, a2, f2, nidx));
            nidx++;
            for (int g = 0; g < gap; g++) begin
                smp_data = (g % 2 == 0) ? 16'sh7fff : -16'sh7fff;
                @(negedge clk);
            end
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic blk(real a1, real f1, real a2, real f2);
        feed(BL, a1, f1, a2, f2, 0);
        settle();
    endtask

    task automatic clear();
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (4) @(negedge clk);
        check("R1 reset", tone_seen, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", tone_seen, 1'b0);

        // R2 / R12: block boundary and output latency
        det_en = 1'b1; db_blocks = 8'd1;
        @(negedge clk);
        feed(BL-1, 8000.0, 2100.0, 0.0, 1000.0, 0);
        settle();
        check("R2 535 samples", tone_seen, 1'b0);
        put(gen(8000.0, 2100.0, 0.0, 1000.0, nidx)); nidx++;
        check("R12 edge+0", tone_seen, 1'b0);
        @(negedge clk);
        check("R12 edge+1", tone_seen, 1'b0);
        @(negedge clk);
        check("R12 edge+2", tone_seen, 1'b1);
        clear();
        check("R9 clear", tone_seen, 1'b0);

        // R3: energy share
        blk(8000.0, 1000.0, 0.0, 1000.0);
        check("R3 1000Hz alone", tone_seen, 1'b0);
        blk(4000.0, 2100.0, 8000.0, 1000.0);
        check("R3 weak 2100", tone_seen, 1'b0);
        blk(8000.0, 2100.0, 2000.0, 1000.0);
        check("R3 strong 2100", tone_seen, 1'b1);
        clear();

        // R4: energy floor
        blk(100.0, 2100.0, 0.0, 1000.0);
        check("R4 below floor", tone_seen, 1'b0);
        blk(300.0, 2100.0, 0.0, 1000.0);
        check("R4 above floor", tone_seen, 1'b1);
        clear();

        // R5: three consecutive blocks
        db_blocks = 8'd3;
        blk(0.0, 2100.0, 0.0, 1000.0);
        blk(8000.0, 2100.0, 0.0, 1000.0);
        blk(8000.0, 2100.0, 0.0, 1000.0);
        check("R5 two of three", tone_seen, 1'b0);
        blk(8000.0, 2100.0, 0.0, 1000.0);
        check("R5 third block", tone_seen, 1'b1);
        clear();

        // R6: a gap restarts the run
        blk(0.0, 2100.0, 0.0, 1000.0);
        blk(8000.0, 2100.0, 0.0, 1000.0);
        blk(8000.0, 2100.0, 0.0, 1000.0);
        blk(0.0, 2100.0, 0.0, 1000.0);
        blk(8000.0, 2100.0, 0.0, 1000.0);
        blk(8000.0, 2100.0, 0.0, 1000.0);
        check("R6 run broken", tone_seen, 1'b0);
        blk(8000.0, 2100.0, 0.0, 1000.0);
        check("R6 run complete", tone_seen, 1'b1);
        clear();

        // R7: zero count acts as one
        db_blocks = 8'd0;
        blk(0.0, 2100.0, 0.0, 1000.0);
        blk(8000.0, 2100.0, 0.0, 1000.0);
        check("R7 count zero", tone_seen, 1'b1);
        clear();

        // R8: sticky through silence
        db_blocks = 8'd1;
        blk(8000.0, 2100.0, 0.0, 1000.0);
        blk(0.0, 2100.0, 0.0, 1000.0);
        blk(0.0, 2100.0, 0.0, 1000.0);
        check("R8 sticky", tone_seen, 1'b1);
        det_en = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 status kept when off", tone_seen, 1'b1);
        det_en = 1'b1;
        @(negedge clk);
        clear();
        check("R9 clear after sticky", tone_seen, 1'b0);

        // R10: run count discarded on disable
        db_blocks = 8'd2;
        blk(0.0, 2100.0, 0.0, 1000.0);
        blk(8000.0, 2100.0, 0.0, 1000.0);
        det_en = 1'b0; @(negedge clk); det_en = 1'b1; @(negedge clk);
        blk(8000.0, 2100.0, 0.0, 1000.0);
        check("R10 run discarded", tone_seen, 1'b0);
        blk(8000.0, 2100.0, 0.0, 1000.0);
        check("R10 run rebuilt", tone_seen, 1'b1);
        clear();

        // R10: samples ignored while off
        db_blocks = 8'd1;
        det_en = 1'b0;
        feed(3*BL, 8000.0, 2100.0, 0.0, 1000.0, 0);
        settle();
        check("R10 samples ignored", tone_seen, 1'b0);
        // R10: partial block discarded
        det_en = 1'b1;
        @(negedge clk);
        feed(300, 8000.0, 2100.0, 0.0, 1000.0, 0);
        det_en = 1'b0; @(negedge clk); det_en = 1'b1; @(negedge clk);
        blk(0.0, 2100.0, 0.0, 1000.0);
        check("R10 partial discarded", tone_seen, 1'b0);

        // R11: cycles without valid do not count
        feed(BL, 8000.0, 2100.0, 0.0, 1000.0, 2);
        settle();
        check("R11 gapped samples", tone_seen, 1'b1);
        clear();
        blk(0.0, 2100.0, 0.0, 1000.0);
        check("R11 realigned silence", tone_seen, 1'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule